// File: doc/BRIEF.md
# Bidirectional Printer Port Register File

This block is the host-side register set of a byte-wide compatibility printer port. A processor reaches it over a small register bus with a two-bit offset and separate read and write strobes. The block keeps an output byte for the data lines and a control byte that drives the four handshake and setup lines. It also assembles a status byte from five lines returned by the attached device. Fixed inversions between register bits and pins live inside the block, so software always sees a positive-logic view of the control byte.

One control bit turns the data drivers off, which makes the port usable for input. A read of the data offset then returns whatever the far end places on the lines. While the drivers are on, the same read returns the driven byte ORed with any external byte.

A second control bit arms an interrupt request. The request is set on a falling edge of the device's acknowledge line, taken through a two-flop synchronizer, and it is held until software reads the status offset. Address decoding of the port base, pin electrical levels and block-transfer modes are handled elsewhere. The data pins appear as separate output, input and output-enable signals.

Top module: `prnport_regs`

## Requirements
- R1: At reset the data output byte is 0x00 and the data drivers are enabled. The line-latch, line-feed and select pins sit at 1, the device-reset pin at 0, the interrupt request at 0, and the control offset reads 0x00.
- R2: Offset 0 is data, offset 1 is status, offset 2 is control. A read places its byte on `bus_rdata` at the clock edge that samples `bus_rd`, and the byte holds until the next read. Offset 3 reads 0xFF and ignores writes.
- R3: Control bit 0 drives the line-latch pin inverted, bit 1 drives the line-feed pin inverted, bit 2 drives the device-reset pin unchanged, and bit 3 drives the select pin inverted. The pins change at the edge that samples the write.
- R4: A control read returns bits 5..0 rebuilt from the currently driven pin, enable and direction state, with bits 7..6 reading 0.
- R5: With control bit 5 set to 1, `pd_oe` is 0 (drivers released). With bit 5 at 0, `pd_oe` is 1.
- R6: A data read returns `pd_in` while the drivers are released, and `pd_out | pd_in` while they are enabled.
- R7: The status byte is bit 7 = inverse of `sts_hold_i`, bit 6 = `sts_done_i`, bit 5 = `sts_nopaper_i`, bit 4 = `sts_online_i`, bit 3 = `sts_fault_i`, and bits 2..0 = 1. The inputs pass a two-flop synchronizer, so a read whose strobe is sampled three or more edges after an input change shows the new value.
- R8: A write to the status offset changes nothing: status, control pins and data output are unaffected.
- R9: With control bit 4 set, a 1-to-0 change of `sts_done_i` sets `irq_o` at the third clock edge after the change. A rising edge does not set it, and neither does any edge while bit 4 is 0.
- R10: Once set, `irq_o` stays 1 until a status read. The status read clears it at the same edge unless a new falling edge is detected in that cycle, in which case the request stays set.
- R11: A write to the data offset updates `pd_out` at the sampling edge, and `pd_out` holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pd_out | output | 8 | Data byte driven to the lines |
| pd_in | input | 8 | Byte observed on the data lines |
| pd_oe | output | 1 | Data line driver enable |
| ctl_lat_o | output | 1 | Data latch handshake pin |
| ctl_feed_o | output | 1 | Automatic line-feed pin |
| ctl_reset_o | output | 1 | Device reset pin |
| ctl_choose_o | output | 1 | Device select pin |
| sts_hold_i | input | 1 | Device cannot accept data |
| sts_done_i | input | 1 | Acknowledge from device |
| sts_nopaper_i | input | 1 | Out-of-paper indication |
| sts_online_i | input | 1 | Device selected indication |
| sts_fault_i | input | 1 | Device fault indication |
| irq_o | output | 1 | Interrupt request level |

## Verification
A wrong inversion or a swapped bit in the control path shows up on the handshake pins at the first edge after a control write. The same fault also shows up in the control read-back on the following read. A broken synchronizer or edge detector makes `irq_o` rise early, late or not at all, which the bench sees within three edges of a falling acknowledge. A wrong direction state shows at once on `pd_oe`, and in the OR-versus-plain result of the next data read. A bad status layout is seen on the first status read after the inputs have settled.

// File: rtl/prnport_pkg.sv
package prnport_pkg;

  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_CTRL = 2;

  localparam int unsigned CB_LAT    = 0;
  localparam int unsigned CB_FEED   = 1;
  localparam int unsigned CB_RST    = 2;
  localparam int unsigned CB_CHOOSE = 3;
  localparam int unsigned CB_IRQEN  = 4;
  localparam int unsigned CB_DIR    = 5;
  localparam int unsigned CTRL_USED = 6;

  localparam int unsigned STS_LINES = 5;

  typedef struct packed {
    logic hold;
    logic done;
    logic nopaper;
    logic online;
    logic fault;
  } sts_t;

endpackage

// File: rtl/prnport_sync.sv
module prnport_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/prnport_ctrl.sv
module prnport_ctrl
  import prnport_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [CTRL_USED-1:0] wdata,
  output logic                 ctl_lat_o,
  output logic                 ctl_feed_o,
  output logic                 ctl_reset_o,
  output logic                 ctl_choose_o,
  output logic                 irq_en_o,
  output logic                 pd_oe_o,
  output logic [DATA_W-1:0]    readback_o
);

  localparam int unsigned PAD_W = DATA_W - CTRL_USED;

  // Pin registers hold the driven levels; the register view is rebuilt from them.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_lat_o    <= 1'b1;
      ctl_feed_o   <= 1'b1;
      ctl_reset_o  <= 1'b0;
      ctl_choose_o <= 1'b1;
      irq_en_o     <= 1'b0;
      pd_oe_o      <= 1'b1;
    end else if (wr_en) begin
      ctl_lat_o    <= ~wdata[CB_LAT];
      ctl_feed_o   <= ~wdata[CB_FEED];
      ctl_reset_o  <=  wdata[CB_RST];
      ctl_choose_o <= ~wdata[CB_CHOOSE];
      irq_en_o     <=  wdata[CB_IRQEN];
      pd_oe_o      <= ~wdata[CB_DIR];
    end
  end

  assign readback_o = {{PAD_W{1'b0}}, ~pd_oe_o, irq_en_o, ~ctl_choose_o,
                       ctl_reset_o, ~ctl_feed_o, ~ctl_lat_o};

  a_r3_pins_follow_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctl_lat_o == !$past(wdata[CB_LAT])) &&
              (ctl_feed_o == !$past(wdata[CB_FEED])) &&
              (ctl_reset_o == $past(wdata[CB_RST])) &&
              (ctl_choose_o == !$past(wdata[CB_CHOOSE])));

  a_r5_dir_drives_oe: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> pd_oe_o == !$past(wdata[CB_DIR]));

  a_r8_pins_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctl_lat_o) && $stable(ctl_feed_o) && $stable(ctl_reset_o) &&
               $stable(ctl_choose_o) && $stable(pd_oe_o) && $stable(irq_en_o));

endmodule

// File: rtl/prnport_stat.sv
module prnport_stat
  import prnport_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  sts_t              lines_i,
  input  logic              irq_en_i,
  input  logic              rd_clr_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);

  localparam int unsigned FILL_W = DATA_W - STS_LINES;

  sts_t sync_q;
  logic done_d;
  logic done_fall;

  prnport_sync #(.STAGES(SYNC_STAGES), .W(STS_LINES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (lines_i),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) done_d <= 1'b0;
    else     done_d <= sync_q.done;
  end

  assign done_fall = done_d & ~sync_q.done;

  // A new edge wins over a clearing read so no event is lost.
  always_ff @(posedge clk) begin
    if (rst)                        irq_o <= 1'b0;
    else if (done_fall && irq_en_i) irq_o <= 1'b1;
    else if (rd_clr_i)              irq_o <= 1'b0;
  end

  assign status_o = {~sync_q.hold, sync_q.done, sync_q.nopaper, sync_q.online,
                     sync_q.fault, {FILL_W{1'b1}}};

  a_r9_edge_sets_irq: assert property (@(posedge clk) disable iff (rst)
    done_fall && irq_en_i |=> irq_o);

  a_r9_disabled_no_irq: assert property (@(posedge clk) disable iff (rst)
    !irq_o && !irq_en_i |=> !irq_o);

  a_r10_irq_holds: assert property (@(posedge clk) disable iff (rst)
    irq_o && !rd_clr_i |=> irq_o);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_clr_i && !done_fall |=> !irq_o);

endmodule

// File: rtl/prnport_regs.sv
module prnport_regs
  import prnport_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] pd_out,
  input  logic [DATA_W-1:0] pd_in,
  output logic              pd_oe,
  output logic              ctl_lat_o,
  output logic              ctl_feed_o,
  output logic              ctl_reset_o,
  output logic              ctl_choose_o,
  input  logic              sts_hold_i,
  input  logic              sts_done_i,
  input  logic              sts_nopaper_i,
  input  logic              sts_online_i,
  input  logic              sts_fault_i,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic              wr_data, wr_ctrl, rd_stat;
  logic              irq_en;
  logic [DATA_W-1:0] ctrl_view;
  logic [DATA_W-1:0] stat_view;
  logic [DATA_W-1:0] data_view;
  logic [DATA_W-1:0] rd_mux;
  sts_t              lines;

  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);

  assign lines = '{hold: sts_hold_i, done: sts_done_i, nopaper: sts_nopaper_i,
                   online: sts_online_i, fault: sts_fault_i};

  always_ff @(posedge clk) begin
    if (rst)          pd_out <= '0;
    else if (wr_data) pd_out <= bus_wdata;
  end

  prnport_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_ctrl),
    .wdata        (bus_wdata[CTRL_USED-1:0]),
    .ctl_lat_o    (ctl_lat_o),
    .ctl_feed_o   (ctl_feed_o),
    .ctl_reset_o  (ctl_reset_o),
    .ctl_choose_o (ctl_choose_o),
    .irq_en_o     (irq_en),
    .pd_oe_o      (pd_oe),
    .readback_o   (ctrl_view)
  );

  prnport_stat #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) stat_i (
    .clk      (clk),
    .rst      (rst),
    .lines_i  (lines),
    .irq_en_i (irq_en),
    .rd_clr_i (rd_stat),
    .status_o (stat_view),
    .irq_o    (irq_o)
  );

  assign data_view = pd_oe ? (pd_out | pd_in) : pd_in;

  always_comb begin
    unique case (bus_addr)
      A_DATA:  rd_mux = data_view;
      A_STAT:  rd_mux = stat_view;
      A_CTRL:  rd_mux = ctrl_view;
      default: rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  a_r11_data_write: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> pd_out == $past(bus_wdata));

  a_r11_data_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_data |=> $stable(pd_out));

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  a_r6_input_read: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (bus_addr == A_DATA) && !pd_oe |=> bus_rdata == $past(pd_in));

endmodule

// File: tb/prnport_regs_tb_top.sv
module prnport_regs_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, pd_out, pd_in = '0;
  logic       pd_oe, ctl_lat_o, ctl_feed_o, ctl_reset_o, ctl_choose_o, irq_o;
  logic       hold = 0, done = 1, nopaper = 0, online = 1, fault = 1;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  prnport_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_out(pd_out), .pd_in(pd_in),
    .pd_oe(pd_oe), .ctl_lat_o(ctl_lat_o), .ctl_feed_o(ctl_feed_o),
    .ctl_reset_o(ctl_reset_o), .ctl_choose_o(ctl_choose_o),
    .sts_hold_i(hold), .sts_done_i(done), .sts_nopaper_i(nopaper),
    .sts_online_i(online), .sts_fault_i(fault), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] exp_stat(logic h, logic dn, logic np, logic on, logic ft);
    return {~h, dn, np, on, ft, 3'b111};
  endfunction

  // {select, device reset, line feed, latch}
  function automatic logic [7:0] exp_pins(logic [7:0] c);
    return {4'b0, ~c[3], c[2], ~c[1], ~c[0]};
  endfunction

  function automatic logic [7:0] pins();
    return {4'b0, ctl_choose_o, ctl_reset_o, ctl_feed_o, ctl_lat_o};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] m_data, m_ctrl;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pins", pins(), 8'h0B);
    chk("R1 pd_oe", {7'b0, pd_oe}, 8'h01);
    chk("R1 pd_out", pd_out, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    brd(2'd2, r); chk("R1 ctrl read", r, 8'h00);

    // R11 / R6 data path
    bwr(2'd0, 8'hA5); chk("R11 pd_out", pd_out, 8'hA5);
    brd(2'd0, r); chk("R6 driven read", r, 8'hA5);
    pd_in = 8'h5A;
    brd(2'd0, r); chk("R6 OR read", r, 8'hFF);

    // R5 direction
    bwr(2'd2, 8'h20); chk("R5 oe off", {7'b0, pd_oe}, 8'h00);
    pd_in = 8'h3C;
    brd(2'd0, r); chk("R6 input read", r, 8'h3C);
    brd(2'd2, r); chk("R4 ctrl 20", r, 8'h20);
    bwr(2'd2, 8'h00); chk("R5 oe on", {7'b0, pd_oe}, 8'h01);

    // R3 pin inversions
    bwr(2'd2, 8'h0F); chk("R3 pins 0F", pins(), exp_pins(8'h0F));
    bwr(2'd2, 8'h05); chk("R3 pins 05", pins(), exp_pins(8'h05));
    bwr(2'd2, 8'hFF); brd(2'd2, r); chk("R4 upper zero", r, 8'h3F);
    bwr(2'd2, 8'h00);

    // R7 status layout
    hold = 1; done = 1; nopaper = 0; online = 0; fault = 1;
    repeat (3) @(negedge clk);
    brd(2'd1, r); chk("R7 status a", r, exp_stat(1, 1, 0, 0, 1));
    hold = 0; done = 0; nopaper = 1; online = 1; fault = 0;
    repeat (3) @(negedge clk);
    brd(2'd1, r); chk("R7 status b", r, exp_stat(0, 0, 1, 1, 0));
    done = 1; repeat (3) @(negedge clk);

    // R8 status write ignored
    bwr(2'd1, 8'h00);
    brd(2'd1, r); chk("R8 status", r, exp_stat(0, 1, 1, 1, 0));
    chk("R8 pins", pins(), exp_pins(8'h00));
    chk("R8 pd_out", pd_out, 8'hA5);

    // R2 offset 3
    bwr(2'd3, 8'h00);
    brd(2'd3, r); chk("R2 off3 read", r, 8'hFF);
    chk("R2 off3 pd_out", pd_out, 8'hA5);
    brd(2'd2, r); chk("R2 off3 ctrl", r, 8'h00);

    // R9 interrupt timing
    bwr(2'd2, 8'h10);
    @(negedge clk); done = 0;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 not yet", {7'b0, irq_o}, 8'h00);
    @(posedge clk); #1;
    chk("R9 set third edge", {7'b0, irq_o}, 8'h01);
    repeat (4) @(negedge clk);
    chk("R10 held", {7'b0, irq_o}, 8'h01);
    brd(2'd1, r); chk("R10 cleared by read", {7'b0, irq_o}, 8'h00);
    done = 1; repeat (5) @(negedge clk);
    chk("R9 rise no irq", {7'b0, irq_o}, 8'h00);
    bwr(2'd2, 8'h00);
    done = 0; repeat (5) @(negedge clk);
    chk("R9 disabled no irq", {7'b0, irq_o}, 8'h00);
    done = 1; repeat (3) @(negedge clk);

    // Random mix against bench model
    m_data = pd_out; m_ctrl = 8'h00;
    for (int i = 0; i < 150; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      if (v[0]) begin m_data = 8'($urandom); bwr(2'd0, m_data); end
      if (v[1]) begin m_ctrl = 8'($urandom) & 8'h2F; bwr(2'd2, m_ctrl); end
      pd_in = 8'($urandom);
      {hold, done, nopaper, online, fault} = 5'($urandom);
      repeat (3) @(negedge clk);
      brd(2'd0, r);
      chk("R6 random data", r, m_ctrl[5] ? pd_in : (m_data | pd_in));
      brd(2'd1, r);
      chk("R7 random status", r, exp_stat(hold, done, nopaper, online, fault));
      brd(2'd2, r); chk("R4 random ctrl", r, m_ctrl & 8'h3F);
      chk("R3 random pins", pins(), exp_pins(m_ctrl));
      chk("R5 random oe", {7'b0, pd_oe}, {7'b0, ~m_ctrl[5]});
      chk("R9 random no irq", {7'b0, irq_o}, 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule